// File: doc/BRIEF.md
# Snapshot-Read 64-bit Free-Running Counter

This block holds a 64-bit up-counter that advances on every clock. Software sees it through a 32-bit register port. A 32-bit bus cannot fetch the whole count in one access, so software first asks for a snapshot. It sets a request bit in a control word, waits until the hardware drops that bit, and then reads two data words. Both words come from one frozen copy of the count, so the two halves always belong together.

The capture completes a fixed number of clocks after the request. That delay is a parameter, so the polling loop has something to wait for. The bus and the counter share one clock. Read data comes back registered, one cycle after the read strobe.

Top module: `latched_counter`

## Requirements
- R1: After a synchronous reset, reads of the control word (0xA0), the low data word (0xA4) and the high data word (0xA8) all return 0.
- R2: The live count is 0 during reset and rises by exactly one on each clock after it, wrapping modulo 2^64. Two snapshots therefore differ by the number of clocks between their requests.
- R3: Writing a word with bit 1 set to 0xA0 starts a capture. Bit 1 of the control word then reads 1 for exactly LATCH_DELAY cycles and returns to 0 once the capture is done.
- R4: The captured value equals the live count in the cycle the request was accepted, plus LATCH_DELAY. Bits 31:0 read at 0xA4 and bits 63:32 read at 0xA8.
- R5: The captured value holds until the next capture completes, so repeated reads of a data word return the same value.
- R6: A request made while a capture is already pending has no effect. In particular it does not restart the delay.
- R7: Writes to 0xA4 and 0xA8 change nothing. A control write with bit 1 clear starts no capture.
- R8: Control bits other than bit 1 read 0. Reads from addresses outside the three registers return 0.
- R9: Read data appears on the output one cycle after the read strobe and shows the state before that clock edge. A data read on the same edge as a capture returns the previous snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for the counter and the register port |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
Two events can fall on the same edge: the capture finishing, and a read of a data word or of the control word. The bench sets this up by issuing a request and then placing a read exactly LATCH_DELAY cycles later. It expects the older snapshot, with the busy bit still at 1, and expects the new value on the next read. A second request placed inside the pending window also lands on a countdown edge. It is judged through the captured value, which must be based on the first request's cycle.

// File: rtl/snapcnt_pkg.sv
package snapcnt_pkg;
  localparam int unsigned REG_W       = 32;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned CTRL_OFS    = 'hA0;
  localparam int unsigned WORD_STRIDE = 4;
  localparam int unsigned REQ_BIT     = 1;
endpackage

// File: rtl/snapcnt_free.sv
module snapcnt_free #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + CNT_W'(1);
  end

  // R2: one step per clock, wrapping naturally
  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> count == $past(count) + CNT_W'(1));
endmodule

// File: rtl/snapcnt_latch.sv
module snapcnt_latch #(
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned LATCH_DELAY = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [CNT_W-1:0] live,
  output logic             busy,
  output logic [CNT_W-1:0] snap
);
  localparam int unsigned DW = $clog2(LATCH_DELAY + 1);

  logic [DW-1:0] dly;
  logic          cap;

  assign cap = busy && (dly == DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      dly  <= '0;
      snap <= '0;
    end else if (busy) begin
      if (cap) begin
        snap <= live;
        busy <= 1'b0;
        dly  <= '0;
      end else begin
        dly <= dly - DW'(1);
      end
    end else if (req) begin
      busy <= 1'b1;
      dly  <= DW'(LATCH_DELAY);
    end
  end

  // R3: busy clears only at the end of the countdown
  assert_busy_fall_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(dly) == DW'(1));
  // R5: snapshot is stable except on a capture edge
  assert_snap_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !cap |=> $stable(snap));
  // R6: a repeated request does not reload the countdown
  assert_absorb_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && req && dly > DW'(1)) |=> busy && dly == $past(dly) - DW'(1));
endmodule

// File: rtl/snapcnt_regs.sv
module snapcnt_regs
  import snapcnt_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              busy,
  input  logic [CNT_W-1:0]  snap,
  output logic              req,
  output logic [REG_W-1:0]  rdata
);
  localparam int unsigned NWORDS = CNT_W / REG_W;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

  logic              ctrl_hit;
  logic [NWORDS-1:0] word_hit;
  logic [REG_W-1:0]  word_val [NWORDS];
  logic [REG_W-1:0]  rmux;

  assign ctrl_hit = (addr == CTRL_A);
  assign req      = wr && ctrl_hit && wdata[REQ_BIT];

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(CTRL_OFS + WORD_STRIDE * (i + 1));
    assign word_hit[i] = (addr == WA);
    assign word_val[i] = snap[i*REG_W +: REG_W];
  end

  always_comb begin
    rmux = '0;
    if (ctrl_hit) rmux[REQ_BIT] = busy;
    for (int i = 0; i < NWORDS; i++) begin
      if (word_hit[i]) rmux = rmux | word_val[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rmux;
  end

  // R8: only the request bit can be set in a control read
  assert_ctrl_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && ctrl_hit) |=> (rdata & ~(REG_W'(1) << REQ_BIT)) == '0);
  // R8: unmapped addresses read zero
  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd && !ctrl_hit && word_hit == '0) |=> rdata == '0);
  // R3: control read reports the pending state seen at the read edge
  assert_ctrl_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (rd && ctrl_hit) |=> rdata[REQ_BIT] == $past(busy));
endmodule

// File: rtl/latched_counter.sv
module latched_counter
  import snapcnt_pkg::*;
#(
  parameter int unsigned CNT_W       = 64,
  parameter int unsigned LATCH_DELAY = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata
);
  logic [CNT_W-1:0] live;
  logic [CNT_W-1:0] snap;
  logic             busy;
  logic             req;

  snapcnt_free #(.CNT_W(CNT_W)) u_free (
    .clk(clk), .rst(rst), .count(live)
  );

  snapcnt_latch #(.CNT_W(CNT_W), .LATCH_DELAY(LATCH_DELAY)) u_latch (
    .clk(clk), .rst(rst), .req(req), .live(live), .busy(busy), .snap(snap)
  );

  snapcnt_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .busy(busy), .snap(snap), .req(req), .rdata(bus_rdata)
  );
endmodule

// File: tb/sim_latched_counter.sv
module sim_latched_counter;
  localparam int DELAY = 2;
  localparam logic [1:0] OP_IDLE = 2'd0, OP_WR = 2'd1, OP_RD = 2'd2;
  localparam logic [7:0] A_CTRL = 8'hA0, A_LO = 8'hA4, A_HI = 8'hA8;
  localparam int NV = 24;
  // {op, addr, wdata}
  localparam logic [41:0] VEC [NV] = '{
    {OP_RD, A_LO, 32'h0},          // R1
    {OP_RD, A_HI, 32'h0},          // R1
    {OP_RD, A_CTRL, 32'h0},        // R1
    {OP_WR, A_CTRL, 32'h2},        // R3 request
    {OP_RD, A_CTRL, 32'h0},        // R3 busy
    {OP_RD, A_CTRL, 32'h0},        // R9 busy on capture edge
    {OP_RD, A_CTRL, 32'h0},        // R3 done
    {OP_RD, A_HI, 32'h0},          // R4
    {OP_RD, A_LO, 32'h0},          // R4
    {OP_RD, A_LO, 32'h0},          // R5 repeat
    {OP_WR, A_LO, 32'hFFFF_FFFF},  // R7
    {OP_WR, A_HI, 32'hFFFF_FFFF},  // R7
    {OP_WR, A_CTRL, 32'hFFFF_FFFD},// R7 bit1 clear
    {OP_RD, A_CTRL, 32'h0},        // R7
    {OP_RD, A_LO, 32'h0},          // R7 unchanged
    {OP_WR, A_CTRL, 32'hFFFF_FFFF},// R8 extra bits ignored
    {OP_WR, A_CTRL, 32'h2},        // R6 absorbed
    {OP_RD, A_LO, 32'h0},          // R9 old value on capture edge
    {OP_RD, A_LO, 32'h0},          // R4 new value
    {OP_RD, A_HI, 32'h0},          // R4
    {OP_RD, 8'hAC, 32'h0},         // R8 unmapped
    {OP_RD, 8'h00, 32'h0},         // R8 unmapped
    {OP_IDLE, 8'h00, 32'h0},
    {OP_RD, A_CTRL, 32'h0}         // R3
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  always #5 clk = ~clk;

  latched_counter #(.LATCH_DELAY(DELAY)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  logic [63:0] ref_cnt = '0;
  always @(posedge clk) ref_cnt <= rst ? 64'd0 : ref_cnt + 64'd1;

  int total = 0, bad = 0, m_cnt = 0;
  logic [63:0] m_snap = '0, m_next = '0;
  bit ended = 0;

  function automatic string tag_of(input logic [7:0] a);
    if (a == A_CTRL) return "R3";
    if (a == A_LO || a == A_HI) return "R4";
    return "R8";
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] op, input logic [7:0] a, input logic [31:0] d,
                     input string tag);
    logic [31:0] exp;
    bus_wr = (op == OP_WR); bus_rd = (op == OP_RD);
    bus_addr = a; bus_wdata = d;
    exp = '0;
    if (a == A_CTRL) exp[1] = (m_cnt != 0);
    else if (a == A_LO) exp = m_snap[31:0];
    else if (a == A_HI) exp = m_snap[63:32];
    if (m_cnt != 0) begin
      m_cnt--;
      if (m_cnt == 0) m_snap = m_next;
    end else if (op == OP_WR && a == A_CTRL && d[1]) begin
      m_cnt = DELAY;
      m_next = ref_cnt + 64'(DELAY);
    end
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    if (op == OP_RD) check(bus_rdata, exp, tag);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    m_cnt = 0; m_snap = '0;
    rst = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] s1;
    @(negedge clk);
    do_reset();
    for (int i = 0; i < NV; i++)
      cyc(VEC[i][41:40], VEC[i][39:32], VEC[i][31:0], tag_of(VEC[i][39:32]));

    // R2: two snapshots differ by the clocks between their requests
    cyc(OP_WR, A_CTRL, 32'h2, "R2");
    repeat (DELAY) cyc(OP_IDLE, 8'h0, 32'h0, "R2");
    s1 = m_snap;
    cyc(OP_RD, A_LO, 32'h0, "R2");
    repeat (10) cyc(OP_IDLE, 8'h0, 32'h0, "R2");
    cyc(OP_WR, A_CTRL, 32'h2, "R2");
    repeat (DELAY) cyc(OP_IDLE, 8'h0, 32'h0, "R2");
    cyc(OP_RD, A_LO, 32'h0, "R2");
    total++;
    if (m_snap - s1 != 64'(DELAY + 1 + 10 + 1)) begin
      bad++;
      $display("FAIL R2 actual=%0d expected=%0d", m_snap - s1, DELAY + 12);
    end

    // R1: reset in the middle of a pending capture
    cyc(OP_WR, A_CTRL, 32'h2, "R1");
    do_reset();
    cyc(OP_RD, A_CTRL, 32'h0, "R1");
    cyc(OP_RD, A_LO, 32'h0, "R1");
    cyc(OP_RD, A_HI, 32'h0, "R1");
    repeat (DELAY + 1) cyc(OP_RD, A_CTRL, 32'h0, "R1");
    finish_run();
  end
endmodule